// File: doc/BRIEF.md
# Program-Counter Register Bank

This block is the architectural register store of a small pipelined core. It holds sixteen 32-bit registers. Index 15 is the program counter. The datapath reaches every register through two general read ports and one general write port. The fetch logic has its own read port and its own write port, and both of these reach only the program counter. Fetch can therefore read and advance the program counter in the same cycle that an executing instruction uses the general ports.

Reads are combinational. Writes take effect on the rising clock edge. The program counter holds the fetch address, and the general read ports present it two words ahead, so an instruction that names index 15 as a source sees the value its pipeline depth implies. A general write to index 15 acts as a branch. It therefore takes precedence over the sequential update that fetch offers through its own port in the same cycle. Every value written into the program counter is forced to word alignment.

Top module: `pc_regbank`

## Requirements
- R1: A general write with `wrEn` high stores `wrData` into register `wrAddr` (0 to 14) at the rising edge. The new value is visible on either general read port from the following cycle.
- R2: Both general read ports are combinational. A read of a register that is being written in the same cycle returns the value held before that edge, on the general ports and on `pcRdData` alike.
- R3: A general read of index 15 returns the stored program counter plus 8, modulo 2^32.
- R4: `pcRdData` always returns the stored program counter without any offset, whatever addresses the general ports select.
- R5: With `pcWrEn` high and no general write to index 15, the program counter takes `pcWrData` at the rising edge.
- R6: When the general port writes index 15 and `pcWrEn` is high in the same cycle, the program counter takes the general `wrData` and the `pcWrData` value is discarded.
- R7: Every write into the program counter, from either port, clears bits [1:0]. Registers 0 to 14 store all 32 bits unchanged.
- R8: A synchronous active-high `rst` sets the program counter to 0 and takes priority over both write ports. Registers 0 to 14 are not initialised.
- R9: A dedicated program-counter write and a general write to a register other than 15 in the same cycle both take effect.
- R10: With `wrEn` low, no general register changes, whatever `wrAddr` and `wrData` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| rdAddrA | input | 4 | General read port A register index |
| rdDataA | output | 32 | General read port A data (index 15 reads PC+8) |
| rdAddrB | input | 4 | General read port B register index |
| rdDataB | output | 32 | General read port B data (index 15 reads PC+8) |
| wrEn | input | 1 | General write enable |
| wrAddr | input | 4 | General write register index |
| wrData | input | 32 | General write data |
| pcRdData | output | 32 | Dedicated program-counter read, no offset |
| pcWrEn | input | 1 | Dedicated program-counter write enable |
| pcWrData | input | 32 | Dedicated program-counter write data |

## Verification
The interesting collision is a branch-style general write to index 15 in the same cycle that fetch offers its sequential update on the dedicated port. The bench drives both enables together with deliberately misaligned values. It then judges the outcome on `pcRdData` and on a general read of index 15 after the edge: the general value must win, with bits [1:0] cleared and the +8 view on the general port. A second overlap also appears in the same bench: a dedicated update alongside a general write to an ordinary register, where both writes must land. Same-cycle read-before-write is sampled just before the edge and again after it.

// File: rtl/pc_regbank_pkg.sv
package pc_regbank_pkg;

  parameter int unsigned RB_REG_CNT = 16;

  typedef enum logic [1:0] {
    PC_KEEP     = 2'd0,
    PC_LOAD_GEN = 2'd1,
    PC_LOAD_DED = 2'd2,
    PC_CLEAR    = 2'd3
  } pcSrc_e;

  typedef struct packed {
    logic [RB_REG_CNT-2:0] gprWe;
    pcSrc_e                pcSrc;
  } bankStrobes_t;

endpackage

// File: rtl/pc_regbank_ctrl.sv
module pc_regbank_ctrl
  import pc_regbank_pkg::*;
#(
  parameter int unsigned REG_CNT = RB_REG_CNT,
  localparam int unsigned AW     = $clog2(REG_CNT),
  localparam int unsigned PC_IDX = REG_CNT - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic          pcWrEn,
  output bankStrobes_t  strobes
);

  logic genHitsPc;
  assign genHitsPc = wrEn && (wrAddr == AW'(PC_IDX));

  for (genvar i = 0; i < PC_IDX; i++) begin : g_we
    assign strobes.gprWe[i] = wrEn && (wrAddr == AW'(i));
  end

  always_comb begin
    if (rst)            strobes.pcSrc = PC_CLEAR;
    else if (genHitsPc) strobes.pcSrc = PC_LOAD_GEN;
    else if (pcWrEn)    strobes.pcSrc = PC_LOAD_DED;
    else                strobes.pcSrc = PC_KEEP;
  end

  // R10
  gpr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (strobes.gprWe == '0));

  // R1
  gpr_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes.gprWe));

  // R6
  gen_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && pcWrEn && wrAddr == AW'(PC_IDX)) |-> (strobes.pcSrc != PC_LOAD_DED));

endmodule

// File: rtl/pc_regbank_dp.sv
module pc_regbank_dp
  import pc_regbank_pkg::*;
#(
  parameter int unsigned REG_CNT    = RB_REG_CNT,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PC_RD_OFS  = 8,
  parameter int unsigned ALIGN_BITS = 2,
  localparam int unsigned AW        = $clog2(REG_CNT),
  localparam int unsigned PC_IDX    = REG_CNT - 1,
  localparam logic [DATA_W-1:0] ALIGN_MASK =
    {{(DATA_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  bankStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcWrData,
  input  logic [AW-1:0]     rdAddrA,
  input  logic [AW-1:0]     rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] pcQ
);

  logic [DATA_W-1:0] regView [REG_CNT];

  for (genvar i = 0; i < PC_IDX; i++) begin : g_gpr
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (strobes.gprWe[i]) q <= wrData;
    end
    assign regView[i] = q;
  end

  always_ff @(posedge clk) begin
    unique case (strobes.pcSrc)
      PC_CLEAR:    pcQ <= '0;
      PC_LOAD_GEN: pcQ <= wrData & ALIGN_MASK;
      PC_LOAD_DED: pcQ <= pcWrData & ALIGN_MASK;
      default:     pcQ <= pcQ;
    endcase
  end

  assign regView[PC_IDX] = pcQ + DATA_W'(PC_RD_OFS);

  assign rdDataA = regView[rdAddrA];
  assign rdDataB = regView[rdAddrB];

  // R7
  pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    pcQ[ALIGN_BITS-1:0] == '0);

  // R5
  ded_load_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.pcSrc == PC_LOAD_DED) |=> (pcQ == ($past(pcWrData) & ALIGN_MASK)));

  // R6
  gen_load_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.pcSrc == PC_LOAD_GEN) |=> (pcQ == ($past(wrData) & ALIGN_MASK)));

endmodule

// File: rtl/pc_regbank.sv
module pc_regbank
  import pc_regbank_pkg::*;
#(
  parameter int unsigned REG_CNT    = RB_REG_CNT,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PC_RD_OFS  = 8,
  parameter int unsigned ALIGN_BITS = 2,
  localparam int unsigned AW        = $clog2(REG_CNT),
  localparam int unsigned PC_IDX    = REG_CNT - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [AW-1:0]     rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] pcRdData,
  input  logic              pcWrEn,
  input  logic [DATA_W-1:0] pcWrData
);

  bankStrobes_t strobes;

  pc_regbank_ctrl #(.REG_CNT(REG_CNT)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .pcWrEn  (pcWrEn),
    .strobes (strobes)
  );

  pc_regbank_dp #(
    .REG_CNT   (REG_CNT),
    .DATA_W    (DATA_W),
    .PC_RD_OFS (PC_RD_OFS),
    .ALIGN_BITS(ALIGN_BITS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrData   (wrData),
    .pcWrData (pcWrData),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .rdDataA  (rdDataA),
    .rdDataB  (rdDataB),
    .pcQ      (pcRdData)
  );

  // R8
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pcRdData == '0));

  // R3
  pc_view_chk: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == AW'(PC_IDX)) |-> (rdDataB == pcRdData + DATA_W'(PC_RD_OFS)));

  // R1
  gpr_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != AW'(PC_IDX)) |=>
      ((rdAddrA != $past(wrAddr)) || (rdDataA == $past(wrData))));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pcWrEn && !(wrEn && wrAddr == AW'(PC_IDX))) |=> $stable(pcRdData));

endmodule

// File: tb/tb_pc_regbank.sv
module tb_pc_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic        we;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic        pwe;
    logic [31:0] pwd;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
    logic [31:0] ep;
  } vec_t;

  // Expected values hold after the edge that applies each vector's writes.
  localparam vec_t VEC [NVEC] = '{
    // R1 R3: write r1, B reads PC(0)+8
    '{1'b1, 4'd1,  32'h11111111, 1'b0, 32'h00000000, 4'd1,  4'd15, 32'h11111111, 32'h00000008, 32'h00000000},
    // R9 R5 R7: r2 keeps low bits, PC advances by 4 in the same cycle
    '{1'b1, 4'd2,  32'hA5A5A5A7, 1'b1, 32'h00000004, 4'd2,  4'd15, 32'hA5A5A5A7, 32'h0000000C, 32'h00000004},
    // R5 R4: sequential fetch update only
    '{1'b0, 4'd0,  32'h00000000, 1'b1, 32'h00000008, 4'd1,  4'd2,  32'h11111111, 32'hA5A5A5A7, 32'h00000008},
    // R6 R7: general write to r15 beats dedicated, aligned
    '{1'b1, 4'd15, 32'h00001003, 1'b1, 32'h00000100, 4'd15, 4'd1,  32'h00001008, 32'h11111111, 32'h00001000},
    // R10: disabled write leaves r1 and PC alone
    '{1'b0, 4'd1,  32'hDEADBEEF, 1'b0, 32'h00000000, 4'd1,  4'd15, 32'h11111111, 32'h00001008, 32'h00001000},
    // R7: dedicated write misaligned
    '{1'b0, 4'd0,  32'h00000000, 1'b1, 32'h0000100F, 4'd15, 4'd15, 32'h00001014, 32'h00001014, 32'h0000100C},
    // R3 R9: offset wraps at top of address space
    '{1'b1, 4'd14, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFC, 4'd14, 4'd15, 32'hFFFFFFFF, 32'h00000004, 32'hFFFFFFFC},
    // R1: register 0 is an ordinary register
    '{1'b1, 4'd0,  32'h12345678, 1'b0, 32'h00000000, 4'd0,  4'd14, 32'h12345678, 32'hFFFFFFFF, 32'hFFFFFFFC}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData, pcRdData, pcWrData;
  logic        wrEn, pcWrEn;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_regbank dut (
    .clk      (clk),
    .rst      (rst),
    .rdAddrA  (rdAddrA),
    .rdDataA  (rdDataA),
    .rdAddrB  (rdAddrB),
    .rdDataB  (rdDataB),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .pcRdData (pcRdData),
    .pcWrEn   (pcWrEn),
    .pcWrData (pcWrData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                       input logic pwe, input logic [31:0] pwd,
                       input logic [3:0] ra, input logic [3:0] rb);
    wrEn = we; wrAddr = wa; wrData = wd;
    pcWrEn = pwe; pcWrData = pwd;
    rdAddrA = ra; rdAddrB = rb;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 4'd15, 4'd15);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R8: PC cleared; R3: general view is 0+8
    chk("R8 reset pc", pcRdData, 32'h0);
    chk("R3 reset view", rdDataA, 32'h8);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].pwe, VEC[i].pwd, VEC[i].ra, VEC[i].rb);
      @(negedge clk);
      chk($sformatf("R1 vec%0d portA", i), rdDataA, VEC[i].ea);
      chk($sformatf("R3 vec%0d portB", i), rdDataB, VEC[i].eb);
      chk($sformatf("R4 vec%0d pc", i), pcRdData, VEC[i].ep);
    end

    // R2: read-before-write on a general register
    drive(1'b1, 4'd3, 32'hAAAA0000, 1'b0, 32'h0, 4'd3, 4'd0);
    @(negedge clk);
    drive(1'b1, 4'd3, 32'h55550000, 1'b0, 32'h0, 4'd3, 4'd0);
    #1;
    chk("R2 old gpr value", rdDataA, 32'hAAAA0000);
    @(negedge clk);
    chk("R1 new gpr value", rdDataA, 32'h55550000);

    // R2: read-before-write on the PC, both views
    drive(1'b0, 4'd0, 32'h0, 1'b1, 32'h00000040, 4'd15, 4'd3);
    #1;
    chk("R2 old pc view", rdDataA, 32'h00000004);
    chk("R2 old pc raw", pcRdData, 32'hFFFFFFFC);
    @(negedge clk);
    chk("R5 new pc view", rdDataA, 32'h00000048);
    chk("R10 r3 kept", rdDataB, 32'h55550000);

    // R8: reset beats both write ports
    rst = 1'b1;
    drive(1'b1, 4'd15, 32'h00000200, 1'b1, 32'h00000300, 4'd15, 4'd3);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 4'd15, 4'd3);
    chk("R8 reset priority pc", pcRdData, 32'h0);
    chk("R3 view after reset", rdDataA, 32'h8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule